// File: doc/BRIEF.md
# Sparse Source Link Multiplexer

This block gathers the contents of many small source memories, most of which hold nothing in a given event window, into one tagged word stream. It then rebuilds those contents in a matching set of destination memories at the far end of a link. On the sending side, a scanner takes a snapshot of every source's fill level when a window opens. It then serves the non-empty sources in turn, lowest index first. It reads one entry per cycle and puts each word on the stream with the number of the source it came from.

A fixed-length register chain models the link's transit time. On the receiving side, a router reads the tag of each arriving word and writes the word to the next free slot of the destination memory with the same index. A start-of-window marker travels in the stream, so the receiver knows when to reset its per-destination write indices. The same pair can be instantiated again for a return path.

Top module: `lmx_link_mux`

## Requirements
- R1: At most one source read enable is high in any cycle. A source with snapshot count C is read at addresses 0, 1, ..., C-1 on consecutive cycles. The source memories return read data one cycle after the request.
- R2: The scanner picks the lowest-index source that still has unread entries. It reads all of that source's entries before it picks another. The next source's first read follows the previous source's last read with no idle cycle between them.
- R3: Each read request produces a stream word two cycles later. The word has `link_valid`=1, `link_tag` set to the source index, and `link_data` set to the entry read.
- R4: When `evt_start` is high, the source counts are captured at that clock edge and every source becomes unread. No read is issued in that cycle. Any source being drained is abandoned, but words already requested are still delivered.
- R5: In every cycle that carries no word, `link_valid` is 0 and `link_tag` and `link_data` are both 0.
- R6: A source count larger than DEPTH is handled as if it were DEPTH.
- R7: A stream word is written at the receiver LINK_DELAY cycles after it appears on the stream. The write raises the single `dst_wr_en` bit selected by the tag. The address is the number of words already written to that destination in the current window, starting at 0.
- R8: `link_sow` is high for one cycle, two cycles after `evt_start`. When that marker reaches the receiver, all destination write indices return to 0.
- R9: Sources with a count of zero are skipped and use no stream cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_start | input | 1 | Opens a new event window |
| src_count | input | N_SRC*CNT_W | Per-source fill level, source i at bits [i*CNT_W +: CNT_W] |
| src_rd_en | output | N_SRC | One-hot read enable for the source memories |
| src_rd_addr | output | ADDR_W | Read address, shared by all sources |
| src_rd_data | input | N_SRC*DATA_W | Read data, source i at bits [i*DATA_W +: DATA_W] |
| link_valid | output | 1 | Stream word valid |
| link_sow | output | 1 | Start-of-window marker on the stream |
| link_tag | output | TAG_W | Source index of the stream word |
| link_data | output | DATA_W | Stream payload |
| dst_wr_en | output | N_SRC | One-hot destination write enable |
| dst_wr_addr | output | ADDR_W | Destination write address |
| dst_wr_data | output | DATA_W | Destination write data |

## Verification
Each stream word and each destination write is compared with a scoreboard entry that includes its expected cycle. A scanner that left a bubble between sources, read them out of order, or failed to skip empty ones would therefore be caught as a timing mismatch, not only as a data error. A window is reopened while a source is still being drained. A scanner that dropped words already requested, or kept reading the old source, would send extra words or lose words. A receiver that did not reset its write indices would write the new window at addresses above zero. One source reports a count above DEPTH: without clamping, the scanner would send more than DEPTH words and the address would wrap. A window with no data at all checks that idle words stay fully zero.

// File: rtl/lmx_pkg.sv
package lmx_pkg;

    localparam int LMX_N_SRC_DEF  = 8;
    localparam int LMX_DEPTH_DEF  = 16;
    localparam int LMX_DATA_W_DEF = 16;
    localparam int LMX_DELAY_DEF  = 76;

    // Control bits that ride along with every stream word.
    typedef struct packed {
        logic sow;
        logic valid;
    } lmx_ctl_t;

    // Index width that never collapses to zero bits.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/lmx_tx_scan.sv
module lmx_tx_scan
    import lmx_pkg::*;
#(
    parameter int N_SRC  = LMX_N_SRC_DEF,
    parameter int DEPTH  = LMX_DEPTH_DEF,
    parameter int DATA_W = LMX_DATA_W_DEF,
    localparam int TAG_W  = idx_w(N_SRC),
    localparam int ADDR_W = idx_w(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    evt_start,
    input  logic [N_SRC*CNT_W-1:0]  src_count,
    output logic [N_SRC-1:0]        src_rd_en,
    output logic [ADDR_W-1:0]       src_rd_addr,
    input  logic [N_SRC*DATA_W-1:0] src_rd_data,
    output lmx_ctl_t                out_ctl,
    output logic [TAG_W-1:0]        out_tag,
    output logic [DATA_W-1:0]       out_data
);

    logic [CNT_W-1:0] snap_q [N_SRC];
    logic [N_SRC-1:0] done_q;
    logic             busy_q;
    logic [TAG_W-1:0] cur_q;
    logic [CNT_W-1:0] ptr_q;

    logic [N_SRC-1:0] pending;
    logic             any_pending;
    logic [TAG_W-1:0] pick;
    logic [TAG_W-1:0] sel_now;
    logic [CNT_W-1:0] ptr_now;
    logic [CNT_W-1:0] sel_cnt;
    logic             fire;
    logic             last;

    function automatic logic [CNT_W-1:0] clamp_cnt(input logic [CNT_W-1:0] c);
        return (c > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : c;
    endfunction

    // Priority encoder: lowest index with unread entries wins.
    always_comb begin
        pick = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            pending[i] = (snap_q[i] != '0) && !done_q[i];
            if (pending[i]) pick = TAG_W'(i);
        end
        any_pending = |pending;
    end

    always_comb begin
        sel_now     = busy_q ? cur_q : pick;
        ptr_now     = busy_q ? ptr_q : '0;
        sel_cnt     = snap_q[sel_now];
        fire        = !evt_start && (busy_q || any_pending);
        last        = (ptr_now + CNT_W'(1)) == sel_cnt;
        src_rd_addr = ptr_now[ADDR_W-1:0];
    end

    generate
        for (genvar g = 0; g < N_SRC; g++) begin : g_rd_en
            assign src_rd_en[g] = fire && (sel_now == TAG_W'(g));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_SRC; i++) snap_q[i] <= '0;
            done_q <= '0;
            busy_q <= 1'b0;
            cur_q  <= '0;
            ptr_q  <= '0;
        end else if (evt_start) begin
            for (int i = 0; i < N_SRC; i++)
                snap_q[i] <= clamp_cnt(src_count[i*CNT_W +: CNT_W]);
            done_q <= '0;
            busy_q <= 1'b0;
            ptr_q  <= '0;
        end else if (fire) begin
            if (last) begin
                busy_q          <= 1'b0;
                ptr_q           <= '0;
                done_q[sel_now] <= 1'b1;
            end else begin
                busy_q <= 1'b1;
                cur_q  <= sel_now;
                ptr_q  <= ptr_now + CNT_W'(1);
            end
        end
    end

    // Two-stage output: request stage, then data capture stage.
    logic             p1_valid;
    logic             p1_sow;
    logic [TAG_W-1:0] p1_tag;

    always_ff @(posedge clk) begin
        if (rst) begin
            p1_valid <= 1'b0;
            p1_sow   <= 1'b0;
            p1_tag   <= '0;
            out_ctl  <= '0;
            out_tag  <= '0;
            out_data <= '0;
        end else begin
            p1_valid      <= fire;
            p1_sow        <= evt_start;
            p1_tag        <= fire ? sel_now : '0;
            out_ctl.valid <= p1_valid;
            out_ctl.sow   <= p1_sow;
            out_tag       <= p1_valid ? p1_tag : '0;
            out_data      <= p1_valid ? src_rd_data[p1_tag*DATA_W +: DATA_W] : '0;
        end
    end

    // R1: never two sources read at once
    a_r1_onehot_read: assert property (@(posedge clk) disable iff (rst)
        $onehot0(src_rd_en));

    // R4: window opening cycle issues no read
    a_r4_quiet_on_start: assert property (@(posedge clk) disable iff (rst)
        evt_start |-> (src_rd_en == '0));

    // R2: a source mid-drain keeps the read port
    a_r2_hold_source: assert property (@(posedge clk) disable iff (rst)
        ((|src_rd_en) && !last && !evt_start) |=>
            (evt_start || src_rd_en == $past(src_rd_en)));

    // R1: consecutive addresses within a drain
    a_r1_addr_step: assert property (@(posedge clk) disable iff (rst)
        ((|src_rd_en) && !last && !evt_start) |=>
            (evt_start || src_rd_addr == $past(src_rd_addr) + ADDR_W'(1)));

    // R5: idle stream words are clean
    a_r5_idle_clean: assert property (@(posedge clk) disable iff (rst)
        !out_ctl.valid |-> (out_tag == '0 && out_data == '0));

endmodule

// File: rtl/lmx_delay_line.sv
module lmx_delay_line #(
    parameter int W     = 8,
    parameter int DELAY = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    generate
        if (DELAY == 0) begin : g_wire
            assign dout = din;
        end else begin : g_chain
            logic [W-1:0] stage [DELAY];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int k = 0; k < DELAY; k++) stage[k] <= '0;
                end else begin
                    stage[0] <= din;
                    for (int k = 1; k < DELAY; k++) stage[k] <= stage[k-1];
                end
            end
            assign dout = stage[DELAY-1];
        end
    endgenerate

endmodule

// File: rtl/lmx_rx_route.sv
module lmx_rx_route
    import lmx_pkg::*;
#(
    parameter int N_SRC  = LMX_N_SRC_DEF,
    parameter int DEPTH  = LMX_DEPTH_DEF,
    parameter int DATA_W = LMX_DATA_W_DEF,
    localparam int TAG_W  = idx_w(N_SRC),
    localparam int ADDR_W = idx_w(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  lmx_ctl_t          in_ctl,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [DATA_W-1:0] in_data,
    output logic [N_SRC-1:0]  dst_wr_en,
    output logic [ADDR_W-1:0] dst_wr_addr,
    output logic [DATA_W-1:0] dst_wr_data
);

    logic [ADDR_W-1:0] wptr_q [N_SRC];

    generate
        for (genvar g = 0; g < N_SRC; g++) begin : g_wr_en
            assign dst_wr_en[g] = in_ctl.valid && (in_tag == TAG_W'(g));
        end
    endgenerate

    assign dst_wr_addr = wptr_q[in_tag];
    assign dst_wr_data = in_data;

    always_ff @(posedge clk) begin
        if (rst || in_ctl.sow) begin
            for (int i = 0; i < N_SRC; i++) wptr_q[i] <= '0;
        end else if (in_ctl.valid) begin
            wptr_q[in_tag] <= wptr_q[in_tag] + ADDR_W'(1);
        end
    end

    // R7: one destination written per cycle
    a_r7_one_write: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dst_wr_en));

    // R8: first write after the marker lands at slot 0
    a_r8_sow_clears: assert property (@(posedge clk) disable iff (rst)
        in_ctl.sow |=> ((|dst_wr_en) |-> dst_wr_addr == '0));

endmodule

// File: rtl/lmx_link_mux.sv
module lmx_link_mux
    import lmx_pkg::*;
#(
    parameter int N_SRC      = LMX_N_SRC_DEF,
    parameter int DEPTH      = LMX_DEPTH_DEF,
    parameter int DATA_W     = LMX_DATA_W_DEF,
    parameter int LINK_DELAY = LMX_DELAY_DEF,
    localparam int TAG_W  = idx_w(N_SRC),
    localparam int ADDR_W = idx_w(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int WORD_W = 2 + TAG_W + DATA_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    evt_start,
    input  logic [N_SRC*CNT_W-1:0]  src_count,
    output logic [N_SRC-1:0]        src_rd_en,
    output logic [ADDR_W-1:0]       src_rd_addr,
    input  logic [N_SRC*DATA_W-1:0] src_rd_data,
    output logic                    link_valid,
    output logic                    link_sow,
    output logic [TAG_W-1:0]        link_tag,
    output logic [DATA_W-1:0]       link_data,
    output logic [N_SRC-1:0]        dst_wr_en,
    output logic [ADDR_W-1:0]       dst_wr_addr,
    output logic [DATA_W-1:0]       dst_wr_data
);

    lmx_ctl_t          tx_ctl;
    logic [TAG_W-1:0]  tx_tag;
    logic [DATA_W-1:0] tx_data;
    logic [WORD_W-1:0] far_word;
    lmx_ctl_t          far_ctl;
    logic [TAG_W-1:0]  far_tag;
    logic [DATA_W-1:0] far_data;

    lmx_tx_scan #(.N_SRC(N_SRC), .DEPTH(DEPTH), .DATA_W(DATA_W)) u_tx (
        .clk         (clk),
        .rst         (rst),
        .evt_start   (evt_start),
        .src_count   (src_count),
        .src_rd_en   (src_rd_en),
        .src_rd_addr (src_rd_addr),
        .src_rd_data (src_rd_data),
        .out_ctl     (tx_ctl),
        .out_tag     (tx_tag),
        .out_data    (tx_data)
    );

    lmx_delay_line #(.W(WORD_W), .DELAY(LINK_DELAY)) u_link (
        .clk  (clk),
        .rst  (rst),
        .din  ({tx_ctl, tx_tag, tx_data}),
        .dout (far_word)
    );

    assign {far_ctl, far_tag, far_data} = far_word;

    lmx_rx_route #(.N_SRC(N_SRC), .DEPTH(DEPTH), .DATA_W(DATA_W)) u_rx (
        .clk         (clk),
        .rst         (rst),
        .in_ctl      (far_ctl),
        .in_tag      (far_tag),
        .in_data     (far_data),
        .dst_wr_en   (dst_wr_en),
        .dst_wr_addr (dst_wr_addr),
        .dst_wr_data (dst_wr_data)
    );

    assign link_valid = tx_ctl.valid;
    assign link_sow   = tx_ctl.sow;
    assign link_tag   = tx_tag;
    assign link_data  = tx_data;

    // R8: the marker follows the window opening by two cycles
    a_r8_sow_timing: assert property (@(posedge clk) disable iff (rst)
        $past(evt_start, 2) |-> link_sow);

endmodule

// File: tb/lmx_link_mux_test.sv
module lmx_link_mux_test;

    localparam int N      = 8;
    localparam int DEPTH  = 16;
    localparam int DW     = 16;
    localparam int DLY    = 76;
    localparam int TAG_W  = 3;
    localparam int ADDR_W = 4;
    localparam int CNT_W  = 5;

    typedef struct {
        int    tag;
        int    addr;
        int    data;
        int    cyc;
        string req;
    } item_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              evt_start = 1'b0;
    logic [N*CNT_W-1:0] src_count = '0;
    logic [N-1:0]      src_rd_en;
    logic [ADDR_W-1:0] src_rd_addr;
    logic [N*DW-1:0]   src_rd_data = '0;
    logic              link_valid;
    logic              link_sow;
    logic [TAG_W-1:0]  link_tag;
    logic [DW-1:0]     link_data;
    logic [N-1:0]      dst_wr_en;
    logic [ADDR_W-1:0] dst_wr_addr;
    logic [DW-1:0]     dst_wr_data;

    lmx_link_mux uut (
        .clk(clk), .rst(rst), .evt_start(evt_start), .src_count(src_count),
        .src_rd_en(src_rd_en), .src_rd_addr(src_rd_addr), .src_rd_data(src_rd_data),
        .link_valid(link_valid), .link_sow(link_sow), .link_tag(link_tag),
        .link_data(link_data), .dst_wr_en(dst_wr_en), .dst_wr_addr(dst_wr_addr),
        .dst_wr_data(dst_wr_data)
    );

    always #10 clk = ~clk;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cyc      = 0;
    int    last_evt = -100;
    bit    monitor_on = 1'b0;
    bit    reported = 1'b0;
    int    win_cnt [N];
    logic [DW-1:0] mem [N][DEPTH];
    item_t link_q[$];
    item_t dst_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    // Synchronous source memories, one cycle read latency (R1).
    always @(posedge clk) begin
        for (int i = 0; i < N; i++)
            if (src_rd_en[i]) src_rd_data[i*DW +: DW] <= mem[i][src_rd_addr];
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        end
    endtask

    function automatic int word_val(input int w, input int i, input int j);
        return (w * 4096 + i * 256 + j * 7 + 1) & 16'hFFFF;
    endfunction

    // Driver: opens a window at the current negedge, holds for 'hold' cycles.
    task automatic run_window(input int w, input int hold, input string req);
        int k;
        int e;
        int c;
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < DEPTH; j++) mem[i][j] = word_val(w, i, j);
            src_count[i*CNT_W +: CNT_W] = CNT_W'(win_cnt[i]);
        end
        evt_start = 1'b1;
        e = cyc;
        last_evt = e;
        k = 0;
        for (int i = 0; i < N; i++) begin
            c = (win_cnt[i] > DEPTH) ? DEPTH : win_cnt[i];
            for (int j = 0; j < c; j++) begin
                if (k < hold - 1) begin
                    link_q.push_back('{i, j, word_val(w, i, j), e + 3 + k, req});
                    dst_q.push_back('{i, j, word_val(w, i, j), e + 3 + k + DLY, "R7"});
                end
                k++;
            end
        end
        @(negedge clk);
        evt_start = 1'b0;
        repeat (hold - 1) @(negedge clk);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (monitor_on && !rst) begin
            item_t it;
            int    idx;
            check($onehot0(src_rd_en), "R1", "read enables one-hot", int'(src_rd_en), 0);
            if (evt_start)
                check(src_rd_en == '0, "R4", "no read on window start", int'(src_rd_en), 0);
            if (link_sow)
                check(cyc == last_evt + 2, "R8", "marker cycle", cyc, last_evt + 2);
            if (link_valid) begin
                if (link_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected stream word tag", int'(link_tag), -1);
                end else begin
                    it = link_q.pop_front();
                    check(int'(link_tag) == it.tag, it.req, "stream tag", int'(link_tag), it.tag);
                    check(int'(link_data) == it.data, it.req, "stream data", int'(link_data), it.data);
                    check(cyc == it.cyc, it.req, "stream cycle", cyc, it.cyc);
                end
            end else begin
                check(link_tag == '0 && link_data == '0, "R5", "idle word payload",
                      int'(link_data), 0);
            end
            if (dst_wr_en != '0) begin
                check($onehot(dst_wr_en), "R7", "write enables one-hot", int'(dst_wr_en), 1);
                idx = 0;
                for (int i = 0; i < N; i++) if (dst_wr_en[i]) idx = i;
                if (dst_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected destination write", idx, -1);
                end else begin
                    it = dst_q.pop_front();
                    check(idx == it.tag, "R7", "destination index", idx, it.tag);
                    check(int'(dst_wr_addr) == it.addr, "R8", "destination address",
                          int'(dst_wr_addr), it.addr);
                    check(int'(dst_wr_data) == it.data, "R7", "destination data",
                          int'(dst_wr_data), it.data);
                    check(cyc == it.cyc, "R7", "destination cycle", cyc, it.cyc);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", cyc, 0);
        report();
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) win_cnt[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // Reset state
        check(link_valid == 1'b0, "R5", "reset link_valid", int'(link_valid), 0);
        check(dst_wr_en == '0, "R7", "reset dst_wr_en", int'(dst_wr_en), 0);
        check(src_rd_en == '0, "R1", "reset src_rd_en", int'(src_rd_en), 0);
        @(negedge clk);
        monitor_on = 1'b1;

        // Sparse sources, empty ones skipped (R9)
        win_cnt = '{0, 3, 0, 0, 1, 0, 0, 2};
        run_window(1, 40, "R9");

        // Nothing to send at all (R5)
        win_cnt = '{0, 0, 0, 0, 0, 0, 0, 0};
        run_window(2, 10, "R5");

        // Full source and an over-range count (R6)
        win_cnt = '{16, 0, 0, 0, 0, 0, 0, 31};
        run_window(3, 40, "R6");

        // Window reopened mid-drain (R4)
        win_cnt = '{4, 4, 4, 4, 4, 4, 4, 4};
        run_window(4, 6, "R4");

        // Mixed counts, strict ascending order, no gaps (R2)
        win_cnt = '{1, 0, 5, 0, 9, 0, 13, 2};
        run_window(5, 40, "R2");

        repeat (DLY + 20) @(negedge clk);
        check(link_q.size() == 0, "R3", "stream words still expected", link_q.size(), 0);
        check(dst_q.size() == 0, "R7", "writes still expected", dst_q.size(), 0);
        report();
        $finish;
    end

endmodule